// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA

This block sends packets that software has described in a shared, word-addressed memory. Each descriptor is a record of four words. It gives the address of the following descriptor, the word address of a payload buffer, and a mode word that carries ownership flags and the packet length. Software builds a chain of descriptors and marks each one as owned by the hardware. It enables the channel, then writes the address of the first descriptor into the start-pointer register.

The engine reads each descriptor and streams its payload as bytes on a valid/ready interface. A short frame is filled with zero bytes up to the minimum frame size. The engine then writes the mode word back with ownership returned to software, and records the descriptor address in the completion register. When the next pointer is zero, the engine marks end-of-queue in that last descriptor and stops, and the start-pointer register reads zero. Software reads the marker and restarts the engine with a fresh start-pointer write. Software acknowledges finished descriptors by writing their addresses into the completion register.

A descriptor that software still owns is passed over and is not sent. A self-clearing reset bit in the control register stops a walk at any point.

Top module: `desc_tx_dma`

## Requirements
- R1: After reset, tx_valid is low and the control, start-pointer and completion registers all read 0.
- R2: Register select 0 is control: bit 0 enables the channel and bit 1 requests a soft reset. Select 1 is the start pointer and select 2 is the completion pointer. The engine starts only while enabled and with a nonzero start pointer. A start-pointer write is ignored while the engine is busy.
- R3: A descriptor at word address D occupies D (next pointer), D+1 (buffer word address), D+2 (buffer length) and D+3 (mode). In the mode word, bit 31 marks start of packet, bit 30 end of packet, bit 29 hardware ownership and bit 28 end-of-queue. Bits 10:0 hold the packet length in bytes.
- R4: Payload byte 4k+j is bits 8j+7:8j of memory word (buffer + k). One byte moves per cycle with tx_valid and tx_ready both high. tx_data and tx_last hold steady while tx_valid is high and tx_ready is low.
- R5: A frame shorter than MIN_FRAME (60) bytes is sent as exactly 60 bytes, with zero bytes after the payload. A longer frame is sent as exactly its length. tx_last is high only on the final byte of each frame.
- R6: After the final byte, the engine writes the mode word back at D+3 with bit 29 cleared, bit 28 set exactly when the next pointer is zero, and all other bits kept. The completion register then reads D.
- R7: A nonzero next pointer makes the engine continue with that descriptor. After the last descriptor, the start-pointer register reads 0.
- R8: A descriptor whose bit 29 is clear when it is fetched sends no bytes and is not written back. The engine proceeds to that descriptor's next pointer.
- R9: Once the engine has stopped at end-of-queue, a new start-pointer write restarts it.
- R10: Writing 1 to control bit 1 clears the start and completion pointers and abandons any walk in progress, with no further bytes or write-back. The bit reads 0 again from the second cycle after the write.
- R11: Memory reads return data on mem_rdata one cycle after mem_req. A frame of one descriptor causes exactly one memory write, to D+3. mem_req is never high while tx_valid is high.
- R12: Software can write the completion register at any time and reads back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr, combinational |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the request |
| tx_valid | output | 1 | Byte stream valid |
| tx_ready | input | 1 | Byte stream ready |
| tx_data | output | 8 | Byte stream data |
| tx_last | output | 1 | Final byte of a frame |

## Verification
A register write is visible on cfg_rdata just after the clock edge that takes it. The soft-reset bit reads 1 for exactly one cycle, and the pointers read 0 from the edge after that. The engine leaves idle on the edge after an enabled start-pointer write. It spends two cycles on each of the four descriptor reads and two on each payload word load. The mode write-back comes one cycle after the final byte is handshaked, and on the same edge the start pointer takes the next pointer. Because the first byte of a frame takes a variable number of cycles to appear under stall patterns, the bench does not count cycles to it. It polls the start pointer at falling edges until it reads zero, waits a few cycles for the write-back, and then checks the recorded stream, the memory image and the completion register against values computed from the length and seed.

// File: rtl/desc_tx_dma_pkg.sv
package desc_tx_dma_pkg;

    localparam int WORD_W   = 32;
    localparam int LEN_W    = 11;
    localparam int BIT_SOP  = 31;
    localparam int BIT_EOP  = 30;
    localparam int BIT_OWN  = 29;
    localparam int BIT_EOQ  = 28;
    localparam int DESC_WORDS = 4;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_HEAD = 2'd1,
        SEL_DONE = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_FETCH_REQ,
        WK_FETCH_CAP,
        WK_CHECK,
        WK_LOAD_REQ,
        WK_LOAD_CAP,
        WK_SEND,
        WK_RETIRE
    } walk_state_e;

    // number of bytes put on the stream for a given packet length
    function automatic logic [LEN_W-1:0] frame_bytes(input logic [LEN_W-1:0] len,
                                                     input int unsigned floor_b);
        if (32'(len) < floor_b)
            return LEN_W'(floor_b);
        return len;
    endfunction

    // mode word as written back when a descriptor is finished
    function automatic logic [WORD_W-1:0] retire_mode(input logic [WORD_W-1:0] m,
                                                      input logic at_end);
        logic [WORD_W-1:0] r;
        r          = m;
        r[BIT_OWN] = 1'b0;
        r[BIT_EOQ] = at_end;
        return r;
    endfunction

endpackage

// File: rtl/desc_tx_dma_regs.sv
module desc_tx_dma_regs
    import desc_tx_dma_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              busy,
    input  logic              hw_head_we,
    input  logic [ADDR_W-1:0] hw_head_val,
    input  logic              hw_done_we,
    input  logic [ADDR_W-1:0] hw_done_val,
    output logic              enable,
    output logic              srst,
    output logic [ADDR_W-1:0] head
);

    logic              en_q;
    logic              srst_q;
    logic [ADDR_W-1:0] head_q;
    logic [ADDR_W-1:0] done_q;
    logic              wr_ctrl, wr_head, wr_done;
    logic              unused_wbits;

    assign wr_ctrl = cfg_we && (reg_sel_e'(cfg_addr) == SEL_CTRL);
    assign wr_head = cfg_we && (reg_sel_e'(cfg_addr) == SEL_HEAD);
    assign wr_done = cfg_we && (reg_sel_e'(cfg_addr) == SEL_DONE);
    assign unused_wbits = ^cfg_wdata[31:ADDR_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            srst_q <= 1'b0;
            head_q <= '0;
            done_q <= '0;
        end else begin
            srst_q <= wr_ctrl && cfg_wdata[1];
            if (wr_ctrl)
                en_q <= cfg_wdata[0];

            if (srst_q)
                head_q <= '0;
            else if (hw_head_we)
                head_q <= hw_head_val;
            else if (wr_head && !busy)
                head_q <= cfg_wdata[ADDR_W-1:0];

            if (srst_q)
                done_q <= '0;
            else if (hw_done_we)
                done_q <= hw_done_val;
            else if (wr_done)
                done_q <= cfg_wdata[ADDR_W-1:0];
        end
    end

    always_comb begin
        unique case (reg_sel_e'(cfg_addr))
            SEL_CTRL: cfg_rdata = {30'd0, srst_q, en_q};
            SEL_HEAD: cfg_rdata = 32'(head_q);
            SEL_DONE: cfg_rdata = 32'(done_q);
            default:  cfg_rdata = '0;
        endcase
    end

    assign enable = en_q;
    assign srst   = srst_q;
    assign head   = head_q;

endmodule

// File: rtl/desc_tx_dma_lane_pick.sv
module desc_tx_dma_lane_pick #(
    parameter int LANES = 4,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic [8*LANES-1:0] word,
    input  logic [SEL_W-1:0]   lane,
    input  logic               use_data,
    output logic [7:0]         byte_out
);

    logic [7:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[8*g +: 8];
    end

    assign byte_out = use_data ? lanes[lane] : 8'h00;

endmodule

// File: rtl/desc_tx_dma_walker.sv
module desc_tx_dma_walker
    import desc_tx_dma_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int unsigned MIN_FRAME = 60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              srst,
    input  logic              enable,
    input  logic [ADDR_W-1:0] head,
    output logic              busy,
    output logic              hw_head_we,
    output logic [ADDR_W-1:0] hw_head_val,
    output logic              hw_done_we,
    output logic [ADDR_W-1:0] hw_done_val,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic              beat_last,
    output logic              beat_payload,
    output logic [1:0]        beat_lane,
    output logic [31:0]       beat_word
);

    walk_state_e       st_q;
    logic [ADDR_W-1:0] cur_q, nxt_q, buf_q;
    logic [31:0]       mode_q, word_q;
    logic [LEN_W-1:0]  bidx_q;
    logic [1:0]        fidx_q;

    logic [LEN_W-1:0]  len, total, bidx_nx;
    logic              owned, at_end, final_beat;

    assign len        = mode_q[LEN_W-1:0];
    assign total      = frame_bytes(len, MIN_FRAME);
    assign bidx_nx    = bidx_q + LEN_W'(1);
    assign owned      = mode_q[BIT_OWN];
    assign at_end     = (nxt_q == '0);
    assign final_beat = (bidx_q == total - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            st_q   <= WK_IDLE;
            cur_q  <= '0;
            nxt_q  <= '0;
            buf_q  <= '0;
            mode_q <= '0;
            word_q <= '0;
            bidx_q <= '0;
            fidx_q <= '0;
        end else begin
            unique case (st_q)
                WK_IDLE: begin
                    if (enable && head != '0) begin
                        cur_q  <= head;
                        fidx_q <= '0;
                        st_q   <= WK_FETCH_REQ;
                    end
                end
                WK_FETCH_REQ: st_q <= WK_FETCH_CAP;
                WK_FETCH_CAP: begin
                    unique case (fidx_q)
                        2'd0:    nxt_q  <= mem_rdata[ADDR_W-1:0];
                        2'd1:    buf_q  <= mem_rdata[ADDR_W-1:0];
                        2'd2:    ;
                        default: mode_q <= mem_rdata;
                    endcase
                    if (fidx_q == 2'(DESC_WORDS - 1)) begin
                        st_q <= WK_CHECK;
                    end else begin
                        fidx_q <= fidx_q + 2'd1;
                        st_q   <= WK_FETCH_REQ;
                    end
                end
                WK_CHECK: begin
                    bidx_q <= '0;
                    if (!owned)
                        st_q <= WK_IDLE;
                    else if (len != '0)
                        st_q <= WK_LOAD_REQ;
                    else
                        st_q <= WK_SEND;
                end
                WK_LOAD_REQ: st_q <= WK_LOAD_CAP;
                WK_LOAD_CAP: begin
                    word_q <= mem_rdata;
                    st_q   <= WK_SEND;
                end
                WK_SEND: begin
                    if (beat_ready) begin
                        if (final_beat) begin
                            st_q <= WK_RETIRE;
                        end else begin
                            bidx_q <= bidx_nx;
                            if (bidx_nx[1:0] == 2'd0 && bidx_nx < len)
                                st_q <= WK_LOAD_REQ;
                        end
                    end
                end
                default: st_q <= WK_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (st_q)
            WK_FETCH_REQ: begin
                mem_req  = 1'b1;
                mem_addr = cur_q + ADDR_W'(fidx_q);
            end
            WK_LOAD_REQ: begin
                mem_req  = 1'b1;
                mem_addr = buf_q + ADDR_W'(bidx_q >> 2);
            end
            WK_RETIRE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_q + ADDR_W'(DESC_WORDS - 1);
                mem_wdata = retire_mode(mode_q, at_end);
            end
            default: ;
        endcase
    end

    assign busy         = (st_q != WK_IDLE);
    assign hw_head_we   = (st_q == WK_RETIRE) || (st_q == WK_CHECK && !owned);
    assign hw_head_val  = nxt_q;
    assign hw_done_we   = (st_q == WK_RETIRE);
    assign hw_done_val  = cur_q;

    assign beat_valid   = (st_q == WK_SEND);
    assign beat_last    = (st_q == WK_SEND) && final_beat;
    assign beat_payload = (bidx_q < len);
    assign beat_lane    = bidx_q[1:0];
    assign beat_word    = word_q;

endmodule

// File: rtl/desc_tx_dma.sv
module desc_tx_dma
    import desc_tx_dma_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int unsigned MIN_FRAME = 60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last
);

    logic              enable, srst, busy;
    logic [ADDR_W-1:0] head;
    logic              hw_head_we, hw_done_we;
    logic [ADDR_W-1:0] hw_head_val, hw_done_val;
    logic              beat_payload;
    logic [1:0]        beat_lane;
    logic [31:0]       beat_word;

    desc_tx_dma_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .busy        (busy),
        .hw_head_we  (hw_head_we),
        .hw_head_val (hw_head_val),
        .hw_done_we  (hw_done_we),
        .hw_done_val (hw_done_val),
        .enable      (enable),
        .srst        (srst),
        .head        (head)
    );

    desc_tx_dma_walker #(.ADDR_W(ADDR_W), .MIN_FRAME(MIN_FRAME)) u_walk (
        .clk          (clk),
        .rst          (rst),
        .srst         (srst),
        .enable       (enable),
        .head         (head),
        .busy         (busy),
        .hw_head_we   (hw_head_we),
        .hw_head_val  (hw_head_val),
        .hw_done_we   (hw_done_we),
        .hw_done_val  (hw_done_val),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .beat_valid   (tx_valid),
        .beat_ready   (tx_ready),
        .beat_last    (tx_last),
        .beat_payload (beat_payload),
        .beat_lane    (beat_lane),
        .beat_word    (beat_word)
    );

    desc_tx_dma_lane_pick #(.LANES(WORD_W / 8)) u_pick (
        .word     (beat_word),
        .lane     (beat_lane),
        .use_data (beat_payload),
        .byte_out (tx_data)
    );

endmodule

// File: rtl/desc_tx_dma_sva.sv
module desc_tx_dma_sva (
    input logic       clk,
    input logic       rst,
    input logic       srst,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       tx_last,
    input logic       mem_req,
    input logic       mem_we,
    input logic [31:0] mem_wdata
);

    assert_hold_stall_R4: assert property (@(posedge clk) disable iff (rst || srst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    assert_last_in_beat_R5: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid);

    assert_retire_owner_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !mem_wdata[29]);

    assert_abort_R10: assert property (@(posedge clk) disable iff (rst)
        srst |=> (!tx_valid && !mem_req));

    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !mem_req);

endmodule

bind desc_tx_dma desc_tx_dma_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .srst      (srst),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata)
);

// File: tb/desc_tx_dma_test.sv
`timescale 1ns/1ps
module desc_tx_dma_test;

    localparam int AW = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid, tx_last;
    logic        tx_ready = 1'b1;
    logic [7:0]  tx_data;

    always #4 clk = ~clk;

    desc_tx_dma #(.ADDR_W(AW), .MIN_FRAME(60)) uut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last)
    );

    // shared memory model, one-cycle read latency
    logic [31:0] mem [0:4095];
    logic        bk_we = 1'b0;
    logic [11:0] bk_addr = '0;
    logic [31:0] bk_data = '0;
    logic        clr_req = 1'b0;
    int          wr_cnt = 0;
    int          last_wr_addr = -1;

    always @(posedge clk) begin
        if (bk_we) mem[bk_addr] <= bk_data;
        if (clr_req) begin
            wr_cnt = 0;
            last_wr_addr = -1;
        end
        if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr[11:0]] <= mem_wdata;
                wr_cnt = wr_cnt + 1;
                last_wr_addr = int'(mem_addr);
            end else begin
                mem_rdata <= mem[mem_addr[11:0]];
            end
        end
    end

    // stream recorder, ready pattern and watchdog
    logic [7:0] rx_bytes [0:2047];
    logic       rx_lastflag [0:2047];
    int         rx_cnt = 0;
    int         rx_last_n = 0;
    int         cyc = 0;
    logic       stall_mode = 1'b0;
    int         tests = 0;
    int         fails = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (clr_req) begin
            rx_cnt = 0;
            rx_last_n = 0;
            for (int i = 0; i < 2048; i++) rx_lastflag[i] = 1'b0;
        end
        tx_ready = stall_mode ? (((cyc * 7) % 5) != 0) : 1'b1;
        if (tx_valid && tx_ready && rx_cnt < 2048) begin
            rx_bytes[rx_cnt] = tx_data;
            rx_lastflag[rx_cnt] = tx_last;
            if (tx_last) rx_last_n = rx_last_n + 1;
            rx_cnt = rx_cnt + 1;
        end
        if (cyc > 190000) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: actual=%0d expected<190000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int k, input int seed);
        return 8'(k * 13 + seed * 7 + 1);
    endfunction

    function automatic logic [31:0] exp_retire(input logic [31:0] m, input logic at_end);
        logic [31:0] r;
        r = m;
        r[29] = 1'b0;
        r[28] = at_end;
        return r;
    endfunction

    function automatic logic [31:0] mode_of(input int len, input logic own);
        return {1'b1, 1'b1, own, 1'b0, 7'd0, 1'b1, 9'd0, 11'(len)};
    endfunction

    task automatic poke(input int a, input logic [31:0] d);
        @(negedge clk);
        bk_we = 1'b1; bk_addr = 12'(a); bk_data = d;
        @(negedge clk);
        bk_we = 1'b0;
    endtask

    task automatic cfg_write(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input int a, output logic [31:0] d);
        cfg_addr = 2'(a);
        #1;
        d = cfg_rdata;
    endtask

    task automatic reset_rx();
        @(negedge clk);
        #1 clr_req = 1'b1;
        @(negedge clk);
        #1 clr_req = 1'b0;
    endtask

    task automatic make_desc(input int d, input int nxt, input int bufp, input int len,
                             input logic own, input int seed);
        for (int w = 0; w < (len + 3) / 4; w++)
            poke(bufp + w, {pat(4*w+3, seed), pat(4*w+2, seed), pat(4*w+1, seed), pat(4*w, seed)});
        poke(d, 32'(nxt));
        poke(d + 1, 32'(bufp));
        poke(d + 2, 32'(len));
        poke(d + 3, mode_of(len, own));
    endtask

    task automatic wait_stop(input string req);
        logic [31:0] h;
        int n;
        n = 0;
        repeat (4) @(negedge clk);
        do begin
            @(negedge clk);
            cfg_read(1, h);
            n = n + 1;
        end while (h != 0 && n < 20000);
        repeat (3) @(negedge clk);
        check(n < 20000, req, n, 20000);
    endtask

    task automatic check_frame(input string req, input int start, input int len, input int seed);
        int tot, errs;
        logic [7:0] e;
        tot = (len < 60) ? 60 : len;
        errs = 0;
        for (int k = 0; k < tot; k++) begin
            e = (k < len) ? pat(k, seed) : 8'h00;
            if (rx_bytes[start + k] !== e) errs = errs + 1;
            if (rx_lastflag[start + k] !== (k == tot - 1)) errs = errs + 1;
        end
        check(errs == 0, req, errs, 0);
    endtask

    initial begin
        logic [31:0] r;
        int base;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
        cfg_read(0, r); check(r == 0, "R1 ctrl", r, 0);
        cfg_read(1, r); check(r == 0, "R1 head", r, 0);
        cfg_read(2, r); check(r == 0, "R1 done", r, 0);

        cfg_write(0, 32'h1);

        // length sweep: R3 R4 R5 R6 R11
        for (int len = 0; len <= 70; len++) begin
            stall_mode = len[0];
            make_desc(16, 0, 64, len, 1'b1, len);
            reset_rx();
            cfg_write(1, 32'd16);
            wait_stop("R7 stop");
            check(rx_cnt == ((len < 60) ? 60 : len), "R5 byte count", rx_cnt, (len < 60) ? 60 : len);
            check_frame("R4 R5 content", 0, len, len);
            check(mem[19] == exp_retire(mode_of(len, 1'b1), 1'b1), "R6 R3 retire word", mem[19],
                  exp_retire(mode_of(len, 1'b1), 1'b1));
            check(wr_cnt == 1 && last_wr_addr == 19, "R11 single write", last_wr_addr, 19);
            cfg_read(2, r); check(r == 16, "R6 done reg", r, 16);
        end

        // long frame under stalls, R4
        stall_mode = 1'b1;
        make_desc(40, 0, 1600, 300, 1'b1, 9);
        reset_rx();
        cfg_write(1, 32'd40);
        wait_stop("R7 stop");
        check(rx_cnt == 300, "R5 long count", rx_cnt, 300);
        check_frame("R4 long content", 0, 300, 9);

        // chain with a software-owned middle descriptor: R7 R8
        stall_mode = 1'b0;
        make_desc(100, 200, 1000, 9, 1'b1, 3);
        make_desc(200, 300, 1200, 20, 1'b0, 4);
        make_desc(300, 0, 1400, 65, 1'b1, 5);
        reset_rx();
        cfg_write(1, 32'd100);
        wait_stop("R7 stop");
        check(rx_cnt == 125 && rx_last_n == 2, "R7 R8 chain bytes", rx_cnt, 125);
        check_frame("R7 frame one", 0, 9, 3);
        check_frame("R7 frame three", 60, 65, 5);
        check(mem[103] == exp_retire(mode_of(9, 1'b1), 1'b0), "R6 mid eoq clear", mem[103],
              exp_retire(mode_of(9, 1'b1), 1'b0));
        check(mem[203] == mode_of(20, 1'b0), "R8 skipped untouched", mem[203], mode_of(20, 1'b0));
        check(mem[303] == exp_retire(mode_of(65, 1'b1), 1'b1), "R6 tail eoq set", mem[303],
              exp_retire(mode_of(65, 1'b1), 1'b1));
        check(wr_cnt == 2, "R8 write count", wr_cnt, 2);
        cfg_read(2, r); check(r == 300, "R7 done last", r, 300);

        // R9: restart after end-of-queue
        make_desc(800, 0, 1700, 5, 1'b1, 11);
        reset_rx();
        cfg_write(1, 32'd800);
        wait_stop("R9 stop");
        check(rx_cnt == 60, "R9 restart bytes", rx_cnt, 60);
        cfg_read(2, r); check(r == 800, "R9 done", r, 800);

        // skip of a lone unowned descriptor, R8
        make_desc(400, 0, 1800, 12, 1'b0, 2);
        reset_rx();
        cfg_write(1, 32'd400);
        wait_stop("R8 stop");
        check(rx_cnt == 0 && wr_cnt == 0, "R8 lone skip", rx_cnt, 0);
        cfg_read(2, r); check(r == 800, "R8 done kept", r, 800);

        // R2: disabled channel holds, then starts on enable
        cfg_write(0, 32'h0);
        make_desc(500, 0, 1900, 10, 1'b1, 6);
        reset_rx();
        cfg_write(1, 32'd500);
        repeat (30) @(negedge clk);
        check(rx_cnt == 0, "R2 disabled idle", rx_cnt, 0);
        cfg_read(1, r); check(r == 500, "R2 head held", r, 500);
        cfg_write(0, 32'h1);
        wait_stop("R2 stop");
        check(rx_cnt == 60, "R2 enabled run", rx_cnt, 60);

        // R2: start write while busy is ignored
        stall_mode = 1'b1;
        make_desc(600, 0, 2000, 200, 1'b1, 7);
        reset_rx();
        cfg_write(1, 32'd600);
        repeat (10) @(negedge clk);
        cfg_write(1, 32'd700);
        cfg_read(1, r); check(r == 600, "R2 busy write ignored", r, 600);
        wait_stop("R2 stop");
        check(rx_cnt == 200, "R2 busy frame", rx_cnt, 200);
        cfg_read(2, r); check(r == 600, "R2 done", r, 600);

        // R12: software acknowledge write
        cfg_write(2, 32'h1234);
        cfg_read(2, r); check(r == 32'h1234, "R12 done write", r, 32'h1234);

        // R10: soft reset mid-frame
        make_desc(900, 0, 2200, 400, 1'b1, 8);
        reset_rx();
        cfg_write(1, 32'd900);
        repeat (40) @(negedge clk);
        cfg_write(0, 32'h3);
        repeat (2) @(negedge clk);
        cfg_read(1, r); check(r == 0, "R10 head cleared", r, 0);
        cfg_read(2, r); check(r == 0, "R10 done cleared", r, 0);
        cfg_read(0, r); check(r == 1, "R10 bit self clears", r, 1);
        check(tx_valid == 1'b0, "R10 stream stopped", tx_valid, 0);
        base = rx_cnt;
        repeat (30) @(negedge clk);
        check(rx_cnt == base && rx_cnt < 400, "R10 no more bytes", rx_cnt, base);
        check(mem[903] == mode_of(400, 1'b1), "R10 no retire", mem[903], mode_of(400, 1'b1));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule